// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the receive byte stream of an Ethernet MAC and decides, once per frame, whether the frame is kept or dropped. It looks only at the six destination address bytes. Unicast destinations are compared with a programmed station address. The all-ones broadcast destination is always kept. Multicast destinations are looked up in a 64-bit hash table, indexed by six bits of a reflected CRC-32 taken over the address. A promiscuous mode bit keeps every frame. An all-multicast mode bit keeps every multicast frame without a table lookup.

Software loads the table, the station address and the mode bits through a 16-bit register write port. Each write goes into a shadow copy. The shadow copy moves into the working copy at each start of frame, so one decision never mixes old and new settings. Control is a four-state machine:
- IDLE: after reset, waiting for a frame.
- COLLECT: taking address bytes and updating the CRC.
- DECIDE: one cycle that presents the verdict.
- SKIP: ignoring the rest of the frame.

Transitions:
- start (any state to COLLECT on a start-of-frame byte).
- last_byte (COLLECT to DECIDE on the sixth accepted byte).
- done (DECIDE to SKIP when no new frame starts).
- A start-of-frame byte in any state, including COLLECT, restarts evaluation.

Top module: `rx_addr_filter`

## Requirements
- R1: `dec_vld` is high for exactly one cycle, in the cycle that follows the clock edge which takes the sixth destination byte. It is low at all other times, including during and after reset.
- R2: The hash is a CRC-32 with reflected polynomial 0xEDB88320 and an all-ones seed. It takes the address bytes in wire order, least significant bit first, with no final inversion. The raw index is CRC bits [5:0].
- R3: Split the raw index into two fields and reverse the bit order of each:
  - The table byte is the bit-reversed form of index[5:3].
  - The bit within that byte is the bit-reversed form of index[2:0].
  - The selected flat table bit is 8*byte + bit.
  - With both mode bits clear, a non-broadcast multicast frame is accepted exactly when that bit is 1.
- R4: Table word k (register address k, 0..3) holds table byte 2k in bits [7:0] and table byte 2k+1 in bits [15:8].
- R5: A frame is multicast exactly when bit 0 of the first destination byte is 1. For unicast frames the table has no effect.
- R6: With mode bit 0 (promiscuous, register address 7) set, every frame is accepted.
- R7: With mode bit 1 (all-multicast, register address 7) set, every multicast frame is accepted whatever the table holds. Unicast frames still need a station match.
- R8: With promiscuous mode clear, a unicast frame is accepted exactly when its destination equals the station address. Station register j (addresses 4..6) holds station byte 2(j-4) in bits [7:0] and the next byte in bits [15:8]. Byte 0 is the first byte on the wire.
- R9: The destination FF:FF:FF:FF:FF:FF is accepted in every configuration.
- R10: With both mode bits clear, an all-zero table rejects every non-broadcast multicast frame.
- R11: A register write takes effect only from the next start-of-frame. A write made during a frame, or in the same cycle as its start-of-frame byte, does not change that frame's decision.
- R12: A start-of-frame byte in any state restarts evaluation and abandons a partly collected address without a decision. Idle cycles (`rx_vld` low) between bytes are skipped. Bytes after the sixth produce no further decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Marks the byte on `rx_data` as the first byte of a frame (qualified by `rx_vld`) |
| rx_vld | input | 1 | `rx_data` carries a frame byte this cycle |
| rx_data | input | 8 | Receive byte |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0..3 table words, 4..6 station words, 7 mode |
| cfg_wdata | input | 16 | Register write data |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Keep the frame (meaningful while `dec_vld` is high) |

## Verification
The verdict is due exactly one cycle after the clock edge that takes the sixth destination byte. The bench drives on falling edges and reads `dec_vld` and `dec_accept` at the very next falling edge. It also samples every other cycle of the frame, and one trailing cycle, to confirm the strobe is low there. A register write is seen by the first frame whose start-of-frame edge comes after the write edge. The bench therefore places writes before a frame, inside a frame, and on the start-of-frame cycle itself, and compares the frame's verdict and the following frame's verdict against the configuration each one should have used.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DECIDE,
        ST_SKIP
    } rxf_state_e;

    typedef struct packed {
        logic allmulti;
        logic promisc;
    } rxf_mode_t;

    localparam logic [31:0] RXF_CRC_POLY = 32'hEDB88320;
    localparam int          RXF_REG_W    = 16;
    localparam int          RXF_CRC_W    = 32;

endpackage

// File: rtl/rxf_crc_step.sv
module rxf_crc_step #(
    parameter int                  CRC_W = 32,
    parameter logic [CRC_W-1:0]    POLY  = 32'hEDB88320,
    parameter int                  DATA_W = 8
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = crc_in;
        for (int i = 0; i < DATA_W; i++) begin
            if (acc[0] ^ data_in[i]) begin
                acc = (acc >> 1) ^ POLY;
            end else begin
                acc = acc >> 1;
            end
        end
        crc_out = acc;
    end

endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup #(
    parameter int HASH_W = 6,
    localparam int FLD_W    = HASH_W / 2,
    localparam int TBL_BITS = 2 ** HASH_W
) (
    input  logic [HASH_W-1:0]   index,
    input  logic [TBL_BITS-1:0] table_bits,
    output logic                hit
);

    logic [FLD_W-1:0] byte_sel;
    logic [FLD_W-1:0] bit_sel;

    for (genvar g = 0; g < FLD_W; g++) begin : g_rev
        assign byte_sel[g] = index[HASH_W-1-g];
        assign bit_sel[g]  = index[FLD_W-1-g];
    end

    assign hit = table_bits[{byte_sel, bit_sel}];

endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int TBL_BITS = 64,
    parameter int STA_BITS = 48,
    parameter int REG_W    = 16,
    localparam int TBL_WORDS = TBL_BITS / REG_W,
    localparam int STA_WORDS = STA_BITS / REG_W,
    localparam int MODE_ADDR = TBL_WORDS + STA_WORDS,
    localparam int RA_W      = $clog2(MODE_ADDR + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [RA_W-1:0]     addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic                commit,
    output logic [TBL_BITS-1:0] act_tbl,
    output logic [STA_BITS-1:0] act_sta,
    output rxf_mode_t           act_mode
);

    logic [TBL_BITS-1:0] sh_tbl;
    logic [STA_BITS-1:0] sh_sta;
    rxf_mode_t           sh_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_tbl  <= '0;
            sh_sta  <= '0;
            sh_mode <= '0;
        end else if (wr) begin
            for (int k = 0; k < TBL_WORDS; k++) begin
                if (addr == RA_W'(k)) begin
                    sh_tbl[k*REG_W +: REG_W] <= wdata;
                end
            end
            for (int j = 0; j < STA_WORDS; j++) begin
                if (addr == RA_W'(TBL_WORDS + j)) begin
                    sh_sta[j*REG_W +: REG_W] <= wdata;
                end
            end
            if (addr == RA_W'(MODE_ADDR)) begin
                sh_mode.promisc  <= wdata[0];
                sh_mode.allmulti <= wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_tbl  <= '0;
            act_sta  <= '0;
            act_mode <= '0;
        end else if (commit) begin
            act_tbl  <= sh_tbl;
            act_sta  <= sh_sta;
            act_mode <= sh_mode;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int          ADDR_BYTES = 6,
    parameter int          HASH_W     = 6,
    parameter logic [31:0] CRC_POLY   = RXF_CRC_POLY,
    localparam int DA_W     = ADDR_BYTES * 8,
    localparam int TBL_BITS = 2 ** HASH_W,
    localparam int MODE_A   = TBL_BITS / RXF_REG_W + DA_W / RXF_REG_W,
    localparam int RA_W     = $clog2(MODE_A + 1),
    localparam int CNT_W    = $clog2(ADDR_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_sof,
    input  logic                 rx_vld,
    input  logic [7:0]           rx_data,
    input  logic                 cfg_wr,
    input  logic [RA_W-1:0]      cfg_addr,
    input  logic [RXF_REG_W-1:0] cfg_wdata,
    output logic                 dec_vld,
    output logic                 dec_accept
);

    rxf_state_e           state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [RXF_CRC_W-1:0] crc_q;
    logic [RXF_CRC_W-1:0] crc_seed;
    logic [RXF_CRC_W-1:0] crc_nxt;
    logic [DA_W-1:0]      dst_q;
    logic                 frame_start;
    logic [TBL_BITS-1:0]  act_tbl;
    logic [DA_W-1:0]      act_sta;
    rxf_mode_t            act_mode;
    logic                 hash_hit;
    logic                 is_mcast;
    logic                 is_bcast;
    logic                 sta_match;

    assign frame_start = rx_sof & rx_vld;

    rxf_cfg_regs #(
        .TBL_BITS (TBL_BITS),
        .STA_BITS (DA_W),
        .REG_W    (RXF_REG_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .commit   (frame_start),
        .act_tbl  (act_tbl),
        .act_sta  (act_sta),
        .act_mode (act_mode)
    );

    assign crc_seed = frame_start ? '1 : crc_q;

    rxf_crc_step #(
        .CRC_W  (RXF_CRC_W),
        .POLY   (CRC_POLY),
        .DATA_W (8)
    ) u_crc (
        .crc_in  (crc_seed),
        .data_in (rx_data),
        .crc_out (crc_nxt)
    );

    rxf_hash_lookup #(
        .HASH_W (HASH_W)
    ) u_hash (
        .index      (crc_q[HASH_W-1:0]),
        .table_bits (act_tbl),
        .hit        (hash_hit)
    );

    // State register with address capture and CRC accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            crc_q   <= '1;
            dst_q   <= '0;
        end else if (frame_start) begin
            // start: any state
            state_q     <= (ADDR_BYTES == 1) ? ST_DECIDE : ST_COLLECT;
            cnt_q       <= CNT_W'(1);
            crc_q       <= crc_nxt;
            dst_q[7:0]  <= rx_data;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_q <= ST_IDLE;
                end
                ST_COLLECT: begin
                    if (rx_vld) begin
                        dst_q[cnt_q*8 +: 8] <= rx_data;
                        crc_q               <= crc_nxt;
                        cnt_q               <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(ADDR_BYTES - 1)) begin
                            state_q <= ST_DECIDE;   // last_byte
                        end
                    end
                end
                ST_DECIDE: begin
                    state_q <= ST_SKIP;             // done
                end
                ST_SKIP: begin
                    state_q <= ST_SKIP;
                end
            endcase
        end
    end

    assign is_mcast  = dst_q[0];
    assign is_bcast  = &dst_q;
    assign sta_match = (dst_q == act_sta);

    // Outputs
    always_comb begin
        dec_vld    = 1'b0;
        dec_accept = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_COLLECT, ST_SKIP: begin
                dec_vld    = 1'b0;
                dec_accept = 1'b0;
            end
            ST_DECIDE: begin
                dec_vld = 1'b1;
                if (act_mode.promisc || is_bcast) begin
                    dec_accept = 1'b1;
                end else if (is_mcast) begin
                    dec_accept = act_mode.allmulti | hash_hit;
                end else begin
                    dec_accept = sta_match;
                end
            end
        endcase
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DA_W     = 48,
    parameter int TBL_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof,
    input  logic                vld,
    input  logic                dec_vld,
    input  logic                dec_accept,
    input  logic                promisc,
    input  logic                allmulti,
    input  logic [DA_W-1:0]     da,
    input  logic [DA_W-1:0]     sta,
    input  logic [TBL_BITS-1:0] tbl
);

    p_vld_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    p_vld_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(vld));

    p_promisc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && promisc) |-> dec_accept);

    p_allmulti_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && allmulti && da[0]) |-> dec_accept);

    p_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && (&da)) |-> dec_accept);

    p_ucast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !promisc && !da[0]) |-> (dec_accept == (da == sta)));

    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof && vld) |=> ($stable(tbl) && $stable(sta) && $stable(promisc) && $stable(allmulti)));

endmodule

bind rx_addr_filter rxf_checker #(
    .DA_W     (DA_W),
    .TBL_BITS (TBL_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (rx_sof),
    .vld        (rx_vld),
    .dec_vld    (dec_vld),
    .dec_accept (dec_accept),
    .promisc    (act_mode.promisc),
    .allmulti   (act_mode.allmulti),
    .da         (dst_q),
    .sta        (act_sta),
    .tbl        (act_tbl)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_vld = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        dec_vld;
    logic        dec_accept;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_sof     (rx_sof),
        .rx_vld     (rx_vld),
        .rx_data    (rx_data),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .dec_vld    (dec_vld),
        .dec_accept (dec_accept)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic fb;
            fb = c[0] ^ da[k];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        return c;
    endfunction

    function automatic int ref_bit(input logic [47:0] da);
        logic [31:0] c;
        int hi, lo;
        c  = ref_crc(da);
        hi = (c[5] ? 1 : 0) + (c[4] ? 2 : 0) + (c[3] ? 4 : 0);
        lo = (c[2] ? 1 : 0) + (c[1] ? 2 : 0) + (c[0] ? 4 : 0);
        return hi * 8 + lo;
    endfunction

    function automatic logic [47:0] gen_mc(input int i);
        logic [7:0] b0;
        b0 = 8'((i * 29) | 1);
        return {8'(i), 8'h33, 8'(i * 113), 8'(i ^ 8'h5A), 8'(i * 7), b0};
    endfunction

    // one cycle: drive at a falling edge, return at the next falling edge
    task automatic cycle(input logic sof, input logic vld, input logic [7:0] d,
                         input logic wr, input logic [2:0] wa, input logic [15:0] wd);
        rx_sof = sof; rx_vld = vld; rx_data = d;
        cfg_wr = wr; cfg_addr = wa; cfg_wdata = wd;
        @(negedge clk);
        rx_sof = 1'b0; rx_vld = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        cycle(1'b0, 1'b0, 8'h00, 1'b1, a, d);
    endtask

    task automatic load_table(input logic [63:0] t);
        for (int k = 0; k < 4; k++) reg_write(3'(k), t[k*16 +: 16]);
    endtask

    task automatic load_station(input logic [47:0] s);
        for (int j = 0; j < 3; j++) reg_write(3'(4 + j), s[j*16 +: 16]);
    endtask

    // sends a frame; wr_at selects the byte index that carries a register write (-1 none)
    task automatic send_frame(input logic [47:0] da, input int gap, input int tail,
                              input int wr_at, input logic [2:0] wa, input logic [15:0] wd,
                              output logic acc, output bit vld_ok);
        vld_ok = 1;
        for (int i = 0; i < 6; i++) begin
            cycle(i == 0, 1'b1, da[i*8 +: 8], i == wr_at, wa, wd);
            if (i < 5) begin
                if (dec_vld) vld_ok = 0;
                for (int g = 0; g < gap; g++) begin
                    cycle(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 16'h0);
                    if (dec_vld) vld_ok = 0;
                end
            end
        end
        if (!dec_vld) vld_ok = 0;
        acc = dec_accept;
        for (int t = 0; t < tail; t++) begin
            cycle(1'b0, 1'b1, 8'(t + 8'hA0), 1'b0, 3'd0, 16'h0);
            if (dec_vld) vld_ok = 0;
        end
        cycle(1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 16'h0);
        if (dec_vld) vld_ok = 0;
    endtask

    task automatic frame_expect(input logic [47:0] da, input logic exp, input string req);
        logic acc; bit ok;
        send_frame(da, 0, 0, -1, 3'd0, 16'h0, acc, ok);
        check(ok, {req, " strobe timing R1"}, 64'(ok), 64'd1);
        check(acc === exp, req, 64'(acc), 64'(exp));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] sta;
        logic acc; bit ok;

        repeat (4) @(negedge clk);
        check(dec_vld === 1'b0, "R1 reset strobe", 64'(dec_vld), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_vld === 1'b0 && dec_accept === 1'b0, "R1 after reset", 64'({dec_vld, dec_accept}), 64'd0);

        // R2 R3 R4: per address, only its predicted bit set -> accept; all but it -> reject
        for (int i = 0; i < 64; i++) begin
            logic [47:0] da;
            int b;
            da = gen_mc(i);
            b  = ref_bit(da);
            load_table(64'd1 << b);
            frame_expect(da, 1'b1, "R2 R3 R4 single bit hit");
            load_table(~(64'd1 << b));
            frame_expect(da, 1'b0, "R3 R4 all but selected bit");
        end

        // R10 R9: zero table
        load_table(64'd0);
        for (int i = 100; i < 116; i++) frame_expect(gen_mc(i), 1'b0, "R10 zero table rejects");
        frame_expect(48'hFFFF_FFFF_FFFF, 1'b1, "R9 broadcast zero table");

        // R8 R5: station match, table all ones must not help unicast
        sta = 48'h5544_3322_1100 | 48'h0000_0000_00A2;
        load_station(sta);
        load_table('1);
        frame_expect(sta, 1'b1, "R8 station exact match");
        for (int k = 1; k < 48; k++) begin
            frame_expect(sta ^ (48'd1 << k), 1'b0, "R5 R8 one-bit-off unicast");
        end

        // R7: all-multicast
        load_table(64'd0);
        reg_write(3'd7, 16'h0002);
        frame_expect(gen_mc(3), 1'b1, "R7 allmulti multicast");
        frame_expect(48'h0000_0000_0010, 1'b0, "R7 allmulti unicast mismatch");
        frame_expect(sta, 1'b1, "R7 allmulti unicast match");

        // R6: promiscuous
        reg_write(3'd7, 16'h0001);
        frame_expect(48'h0000_0000_0010, 1'b1, "R6 promisc unicast mismatch");
        frame_expect(gen_mc(5), 1'b1, "R6 promisc multicast zero table");
        reg_write(3'd7, 16'h0000);
        frame_expect(48'hFFFF_FFFF_FFFF, 1'b1, "R9 broadcast modes clear");

        // R11: write during a frame
        send_frame(gen_mc(7), 0, 0, 2, 3'd7, 16'h0001, acc, ok);
        check(ok, "R11 strobe timing R1", 64'(ok), 64'd1);
        check(acc === 1'b0, "R11 mid-frame write ignored", 64'(acc), 64'd0);
        frame_expect(gen_mc(7), 1'b1, "R11 write applies next frame");
        // write on the start-of-frame cycle
        send_frame(gen_mc(8), 0, 0, 0, 3'd7, 16'h0000, acc, ok);
        check(acc === 1'b1, "R11 sof-cycle write ignored", 64'(acc), 64'd1);
        frame_expect(gen_mc(8), 1'b0, "R11 sof-cycle write applies next frame");

        // R12: abandon partial frame, gaps, tail bytes
        load_station(48'h0000_0000_0042);
        cycle(1'b1, 1'b1, 8'h01, 1'b0, 3'd0, 16'h0);
        check(dec_vld === 1'b0, "R12 partial no strobe", 64'(dec_vld), 64'd0);
        cycle(1'b0, 1'b1, 8'h02, 1'b0, 3'd0, 16'h0);
        cycle(1'b0, 1'b1, 8'h03, 1'b0, 3'd0, 16'h0);
        check(dec_vld === 1'b0, "R12 partial no strobe", 64'(dec_vld), 64'd0);
        send_frame(48'h0000_0000_0042, 2, 5, -1, 3'd0, 16'h0, acc, ok);
        check(ok, "R12 restart gaps tail single strobe R1", 64'(ok), 64'd1);
        check(acc === 1'b1, "R12 restart decides new address", 64'(acc), 64'd1);
        send_frame(48'h0000_0000_0044, 3, 0, -1, 3'd0, 16'h0, acc, ok);
        check(ok && acc === 1'b0, "R12 gapped unicast mismatch", 64'({ok, acc}), 64'h2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule